// File: doc/BRIEF.md
# Conversion Result Holding Registers with Paired-Read Interlock

This block keeps the most recent analog-to-digital conversion result and presents it to a processor bus as two byte-wide readable registers: an upper byte and a lower byte. A conversion-complete strobe arrives with a 10-bit sample, and the block stores it. A formatting control bit chooses the placement of the sample within the 16 readable bits. In one placement the sample sits at the bottom of the pair. In the other it sits at the top, so that reading the upper byte alone gives an 8-bit result.

Software that needs the full sample reads the lower byte first and the upper byte second. Reading the lower byte closes an interlock, and while it is closed no new sample can enter the registers. A new sample that arrives while the interlock is closed is thrown away, so the two bytes software collects always come from the same conversion. Reading the upper byte opens the interlock again.

A completion flag is raised for every conversion, including one that was thrown away. Software clears the flag by pulsing a clear strobe.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both bytes read 0x00, the interlock is open and the completion flag is low.
- R2: With `align_left` low, `lo_byte` equals sample bits 7..0 and `hi_byte` holds sample bits 9..8 in its bits 1..0, with its bits 7..2 at zero.
- R3: With `align_left` high, `hi_byte` equals sample bits 9..2 and `lo_byte` holds sample bits 1..0 in its bits 7..6, with its bits 5..0 at zero.
- R4: The stored sample is kept unformatted. A change of `align_left` reformats the byte outputs in the same cycle, without a new conversion.
- R5: With the interlock open, a `cvt_done` pulse stores `res_in`, and the new value appears on the byte outputs in the cycle after the pulse.
- R6: A `rd_lo` pulse closes the interlock. A `cvt_done` that arrives in the same cycle as `rd_lo`, or in any later cycle up to and including the cycle of the next `rd_hi`, is discarded and leaves both bytes unchanged.
- R7: After a `rd_hi` pulse the interlock is open from the following cycle, and later conversions update both bytes again.
- R8: Reading only the upper byte (`rd_hi` pulses without `rd_lo`) never closes the interlock. Every conversion then updates the outputs.
- R9: `irq_flag` is high in the cycle after every `cvt_done`, whether or not the sample was stored.
- R10: A pulse on `irq_clr` lowers `irq_flag` in the following cycle. If `cvt_done` arrives in the same cycle, the flag stays high.
- R11: When `rd_lo` and `rd_hi` are pulsed in the same cycle, the interlock is open afterwards. A conversion in that same cycle is still discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cvt_done | input | 1 | One-cycle conversion-complete strobe |
| res_in | input | 10 | Conversion sample, valid with `cvt_done` |
| align_left | input | 1 | 1: sample at top of the byte pair; 0: at bottom |
| rd_lo | input | 1 | Bus read strobe for the lower byte |
| rd_hi | input | 1 | Bus read strobe for the upper byte |
| irq_clr | input | 1 | Pulse to clear the completion flag |
| lo_byte | output | 8 | Lower result byte |
| hi_byte | output | 8 | Upper result byte |
| irq_flag | output | 1 | Conversion-complete flag |

## Verification
The in-line assertions check four things on every cycle:
- The interlock opens and closes on the read strobes.
- A blocked or idle cycle leaves the stored sample untouched.
- The completion flag rises on each conversion and falls on a clear that no conversion overrides.
- The padding bits of both formats read zero.

Only the bench scenarios can show the rest:
- Which sample the bytes actually hold, across the full sweep of 1024 codes in both formats.
- The reformatting when `align_left` changes.
- Whether a sample arriving in the exact cycle of `rd_lo`, `rd_hi` or both is kept or dropped.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAIR_W = 2 * BYTE_W;

  // Place a raw sample inside the 16-bit byte pair. Left placement shifts the
  // sample up so its top bits fill the upper byte; unused bits become zero.
  function automatic logic [PAIR_W-1:0] place_result(
    input logic [PAIR_W-1:0] raw,
    input logic              left,
    input int unsigned       res_w
  );
    logic [PAIR_W-1:0] placed;
    if (left) placed = raw << (PAIR_W - res_w);
    else      placed = raw;
    return placed;
  endfunction

  // Mask of the padding bits that must read zero in a given placement.
  function automatic logic [PAIR_W-1:0] pad_mask(
    input logic        left,
    input int unsigned res_w
  );
    logic [PAIR_W-1:0] ones;
    ones = '1;
    if (left) return ones >> res_w;
    return ones << res_w;
  endfunction

endpackage

// File: rtl/adc_rl_lock.sv
module adc_rl_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic blocked,
  output logic locked
);

  logic locked_q;

  // A low-byte read blocks in its own cycle; the state persists until a high read.
  assign blocked = locked_q | rd_lo;
  assign locked  = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     locked_q <= 1'b0;
    else if (rd_hi) locked_q <= 1'b0;
    else if (rd_lo) locked_q <= 1'b1;
  end

  // R6: a lone low read closes the interlock
  a_r6_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !rd_hi |=> locked_q);
  // R7, R11: any high read opens it
  a_r7_hi_opens: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !locked_q);
  // R8: without a low read the interlock never closes
  a_r8_no_spurious_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q && !rd_lo |=> !locked_q);

endmodule

// File: rtl/adc_rl_store.sv
module adc_rl_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] dout
);

  logic [RES_W-1:0] sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sample_q <= '0;
    else if (wr_en) sample_q <= din;
  end

  assign dout = sample_q;

  // R6: nothing enters the register without a write grant
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sample_q));
  // R5: a granted write lands the sample
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sample_q == $past(din));

endmodule

// File: rtl/adc_rl_flag.sv
module adc_rl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;

  // Set wins over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R9: every completion raises the flag
  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  // R10: an unopposed clear drops it
  a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag_q);
  // R10: the flag only rises on a completion
  a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set && !flag_q |=> !flag_q);

endmodule

// File: rtl/adc_rl_fmt.sv
module adc_rl_fmt #(
  parameter int unsigned RES_W = 10
) (
  input  logic             left,
  input  logic [RES_W-1:0] sample,
  output logic [7:0]       hi,
  output logic [7:0]       lo
);
  import adc_rl_pkg::*;

  logic [PAIR_W-1:0] pair;

  always_comb begin
    pair = place_result(PAIR_W'(sample), left, RES_W);
    hi   = pair[PAIR_W-1:BYTE_W];
    lo   = pair[BYTE_W-1:0];
  end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cvt_done,
  input  logic [RES_W-1:0] res_in,
  input  logic             align_left,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic             irq_clr,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte,
  output logic             irq_flag
);
  import adc_rl_pkg::*;

  // Named internal events, brought out for the assertions
  logic             blocked;
  logic             locked;
  logic             accept;
  logic             dropped;
  logic [RES_W-1:0] stored;

  assign accept  = cvt_done & ~blocked;
  assign dropped = cvt_done &  blocked;

  adc_rl_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .blocked (blocked),
    .locked  (locked)
  );

  adc_rl_store #(.RES_W(RES_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept),
    .din   (res_in),
    .dout  (stored)
  );

  adc_rl_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cvt_done),
    .clr   (irq_clr),
    .flag  (irq_flag)
  );

  adc_rl_fmt #(.RES_W(RES_W)) u_fmt (
    .left   (align_left),
    .sample (stored),
    .hi     (hi_byte),
    .lo     (lo_byte)
  );

  // R6: a dropped sample leaves the stored value alone
  a_r6_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> $stable(stored));
  // R6: while the interlock is held, the bytes cannot move unless the format does
  a_r6_locked_bytes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked && $stable(align_left) |=> $stable(align_left) |-> $stable({hi_byte, lo_byte}) || !$past(locked));
  // R2, R3: padding bits of the active placement read zero
  a_r2_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ({hi_byte, lo_byte} & pad_mask(align_left, RES_W)) == '0);
  // R9: a dropped sample still raises the flag
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> irq_flag);

  initial begin
    if (RES_W <= BYTE_W || RES_W > PAIR_W)
      $error("adc_result_latch: RES_W out of range");
  end

endmodule

// File: tb/adc_result_latch_bench.sv
module adc_result_latch_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cvt_done = 1'b0;
  logic [9:0] res_in = '0;
  logic       align_left = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic       irq_clr = 1'b0;
  logic [7:0] lo_byte, hi_byte;
  logic       irq_flag;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  // Bench-side model
  int  exp_val  = 0;
  bit  exp_lock = 0;
  bit  exp_flag = 0;

  always #2 clk = ~clk;

  adc_result_latch u_adc_result_latch (
    .clk(clk), .rst_n(rst_n), .cvt_done(cvt_done), .res_in(res_in),
    .align_left(align_left), .rd_lo(rd_lo), .rd_hi(rd_hi), .irq_clr(irq_clr),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Check both bytes against the model, in the current placement
  task automatic chk_bytes(input string tag);
    int w, eh, el;
    w  = align_left ? exp_val * 64 : exp_val;
    eh = w / 256;
    el = w % 256;
    chk({tag, " hi"}, int'(hi_byte), eh);
    chk({tag, " lo"}, int'(lo_byte), el);
  endtask

  // One clock cycle of stimulus; returns 1 ns after the edge
  task automatic cyc(input bit d, input int v, input bit rl, input bit rh, input bit c);
    bit blk;
    cvt_done = d; res_in = 10'(v); rd_lo = rl; rd_hi = rh; irq_clr = c;
    @(posedge clk);
    blk = exp_lock | rl;
    if (d && !blk) exp_val = v;
    if (rh) exp_lock = 0; else if (rl) exp_lock = 1;
    if (d) exp_flag = 1; else if (c) exp_flag = 0;
    #1;
    cvt_done = 0; rd_lo = 0; rd_hi = 0; irq_clr = 0;
  endtask

  initial begin
    #20000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 hi in reset", int'(hi_byte), 0);
    chk("R1 lo in reset", int'(lo_byte), 0);
    chk("R1 flag in reset", int'(irq_flag), 0);
    #6 rst_n = 1'b1;
    @(posedge clk); #1;
    chk_bytes("R1 after reset");
    chk("R1 flag after reset", int'(irq_flag), 0);

    // R2 R3 R4 R5: full sweep of sample codes in both placements
    for (int v = 0; v < 1024; v++) begin
      align_left = 1'b0;
      cyc(1, v, 0, 0, 0);
      chk_bytes("R2/R5 right placement");
      align_left = 1'b1; #1;
      chk_bytes("R3/R4 left placement");
    end
    chk("R9 flag after sweep", int'(irq_flag), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10 clear", int'(irq_flag), 0);

    // R6: lock, then a dropped completion, with the flag still raised
    align_left = 1'b0;
    cyc(1, 10'h155, 0, 0, 0);
    chk_bytes("R5 base value");
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 10'h2AA, 0, 0, 0);
    chk_bytes("R6 dropped while locked");
    chk("R6 dropped value absent", int'(lo_byte), 'h55);
    chk("R9 flag on drop", int'(irq_flag), 1);
    align_left = 1'b1; #1;
    chk_bytes("R4 reformat while locked");
    align_left = 1'b0; #1;
    // R6: a completion in the rd_hi cycle is also dropped
    cyc(1, 10'h0F0, 0, 1, 0);
    chk("R6 drop in rd_hi cycle", int'(lo_byte), 'h55);
    // R7: open afterwards
    cyc(1, 10'h3C3, 0, 0, 0);
    chk_bytes("R7 update after unlock");
    chk("R7 value hi", int'(hi_byte), 3);

    // R6: completion in the same cycle as rd_lo is dropped
    cyc(1, 10'h111, 1, 0, 0);
    chk("R6 drop in rd_lo cycle", int'(lo_byte), 'hC3);
    cyc(0, 0, 0, 1, 0);

    // R8: high-only reads never block
    align_left = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 0, 1, 0);
      cyc(1, 37 * k + 500, 0, 0, 0);
      chk_bytes("R8 high-only reads");
      chk("R8 hi value", int'(hi_byte), (37 * k + 500) / 4);
    end

    // R11: both strobes together leave the lock open, same-cycle completion dropped
    align_left = 1'b0;
    cyc(1, 10'h077, 1, 1, 0);
    chk("R11 same-cycle completion dropped", int'(lo_byte), ((37 * 5 + 500) % 256));
    cyc(1, 10'h1EE, 0, 0, 0);
    chk_bytes("R11 open after dual read");
    chk("R11 lo value", int'(lo_byte), 'hEE);

    // R10: clear with a simultaneous completion keeps the flag
    cyc(0, 0, 0, 0, 1);
    chk("R10 plain clear", int'(irq_flag), 0);
    cyc(1, 10'h005, 0, 0, 1);
    chk("R10 completion beats clear", int'(irq_flag), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R9 flag holds", int'(irq_flag), 1);

    // R1: reset mid-lock clears everything
    cyc(0, 0, 1, 0, 0);
    rst_n = 1'b0; #1;
    exp_val = 0; exp_lock = 0; exp_flag = 0;
    chk_bytes("R1 async reset");
    chk("R1 flag async reset", int'(irq_flag), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cyc(1, 10'h2B4, 0, 0, 0);
    chk_bytes("R1 unlocked after reset");

    done_run = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule